// File: doc/BRIEF.md
# Six-Source Masked Priority Interrupt Controller

This block collects interrupt events for a small 8-bit processor and turns them into a single serviced interrupt. Six request bits are kept in a latch register. A bit is set by a rising edge on its source line or by software, and is cleared by software or by the processor's acknowledge. The sources may be external pins, timers, serial I/O or software. A per-source mask and a global enable gate the requests. A programmable priority code then selects one winner. The processor sees a valid flag and a 3-bit source index.

Three byte-wide registers sit on a simple register bus. The request register at FAh is writable and readable, and it is used for polled handling. The mask register at FBh holds the six per-source enables in bits 5:0 and the global enable in bit 7. The priority register at F9h holds the ordering code. Two one-cycle strobes set and clear the global enable. An acknowledge clears the winning request and the global enable together, so a handler is not interrupted again until software re-enables. Requests keep latching while the global enable is clear, so software can poll them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the request bits, the mask bits, the global enable and the priority code are all 0. Reads at FAh, FBh and F9h return 00h, and `irq_valid` is 0.
- R2: A 0-to-1 transition of `src_i[n]` between two clock edges sets request bit n at the second edge. Several sources may set in the same cycle. A source held high after its bit is cleared does not set the bit again.
- R3: Bit 7 of the mask register (FBh) is the global enable. While it is 0, `irq_valid` stays 0, but request bits still latch and can be read at FAh for polling.
- R4: Source n is pending when request bit n, mask bit n (FBh bit n) and the global enable are all 1. `irq_valid` is 1 exactly when some source is pending, and `irq_id` then names a pending source.
- R5: Bits 2:0 of F9h select the group order. The groups are A={0,1}, B={2,3} and C={4,5}, and within a group the lower index ranks higher. The codes are: 0 = A,B,C; 1 = A,C,B; 2 = B,A,C; 3 = B,C,A; 4 = C,A,B; 5 = C,B,A. Codes 6 and 7 behave like code 0. The highest-ranked pending source wins.
- R6: `irq_ack` while `irq_valid` is 1 clears the request bit of `irq_id` and the global enable at that edge. `irq_ack` while `irq_valid` is 0 has no effect.
- R7: `ie_set_i` sets the global enable and `ie_clr_i` clears it, each in one cycle. When both are asserted, clear wins. Either strobe overrides bit 7 of a write to FBh in the same cycle, and an acknowledge overrides `ie_set_i`.
- R8: A write to FAh loads request bits 5:0 and a write to F9h loads bits 5:0 of the priority register. Bits 7:6 of FAh and F9h read 0, and bit 6 of FBh reads 0.
- R9: A source rising edge in the same cycle as an acknowledge of that source, or as a software write of 0 to its bit, leaves the bit set.
- R10: Reads of any address other than F9h, FAh and FBh return 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 6 | Interrupt source lines, rising-edge sensitive |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| ie_set_i | input | 1 | Global enable set strobe |
| ie_clr_i | input | 1 | Global enable clear strobe |
| irq_ack | input | 1 | Acknowledge from the processor |
| irq_valid | output | 1 | A masked, enabled request is pending |
| irq_id | output | 3 | Index of the winning source |

## Verification
The collision that matters most is a new rising edge on a source in the same cycle as that source is being cleared, either by an acknowledge or by a software write of 0 to the request register. The bench provokes both cases by raising the source line on the same negative edge that asserts the acknowledge or the write. After the edge, it reads FAh: the bit must still be 1, and for the acknowledge case the global enable in FBh must be 0. A second collision is that of the enable and disable strobes with each other and with a mask write. The bench judges it by reading bit 7 of FBh.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC  = 6;
  localparam int ID_W     = 3;
  localparam int NUM_GRP  = 3;
  localparam int GRP_W    = 2;
  localparam int CODE_W   = 3;

  // Group sitting at a given slot (0 = highest) for an order code.
  function automatic logic [GRP_W-1:0] grp_at(input logic [CODE_W-1:0] code,
                                              input logic [GRP_W-1:0] slot);
    logic [3*GRP_W-1:0] ord;
    case (code)
      3'd1:    ord = {2'd1, 2'd2, 2'd0};
      3'd2:    ord = {2'd2, 2'd0, 2'd1};
      3'd3:    ord = {2'd0, 2'd2, 2'd1};
      3'd4:    ord = {2'd1, 2'd0, 2'd2};
      3'd5:    ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
    return ord[slot*GRP_W +: GRP_W];
  endfunction

  // Returns {valid, id}; walks from lowest rank up so the top rank overwrites.
  function automatic logic [ID_W:0] pick(input logic [NUM_SRC-1:0] pend,
                                         input logic [CODE_W-1:0] code);
    logic [ID_W:0] r;
    logic [GRP_W-1:0] g;
    r = '0;
    for (int s = NUM_GRP - 1; s >= 0; s--) begin
      g = grp_at(code, GRP_W'(s));
      for (int w = 1; w >= 0; w--) begin
        if (pend[2*int'(g) + w]) r = {1'b1, ID_W'(2*int'(g) + w)};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  output logic [N-1:0] rise
);
  logic [N-1:0] src_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[i] <= 1'b0;
      else        src_q[i] <= src[i];
    end
    assign rise[i] = src[i] & ~src_q[i];
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  REQ_ADDR  = 8'hFA,
  parameter logic [7:0]  MASK_ADDR = 8'hFB,
  parameter logic [7:0]  PRIO_ADDR = 8'hF9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] edge_evt,
  input  logic               ack_fire,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               ie_set,
  input  logic               ie_clr,
  output logic               req_wr,
  output logic [NUM_SRC-1:0] req_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               gie_q,
  output logic [NUM_SRC-1:0] prio_q
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic mask_wr, prio_wr;
  logic [NUM_SRC-1:0] ack_clr, req_base, req_d;
  logic gie_d;

  assign req_wr  = reg_wr && (reg_addr == ADDR_W'(REQ_ADDR));
  assign mask_wr = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));
  assign prio_wr = reg_wr && (reg_addr == ADDR_W'(PRIO_ADDR));

  assign ack_clr  = ack_fire ? (NUM_SRC'(1) << ack_id) : '0;
  assign req_base = req_wr ? reg_wdata[NUM_SRC-1:0] : req_q;
  assign req_d    = (req_base & ~ack_clr) | edge_evt;

  always_comb begin
    if (ack_fire || ie_clr) gie_d = 1'b0;
    else if (ie_set)        gie_d = 1'b1;
    else if (mask_wr)       gie_d = reg_wdata[DATA_W-1];
    else                    gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      req_q <= req_d;
      gie_q <= gie_d;
      if (mask_wr) mask_q <= reg_wdata[NUM_SRC-1:0];
      if (prio_wr) prio_q <= reg_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REQ_ADDR))       reg_rdata = {{PAD_W{1'b0}}, req_q};
    else if (reg_addr == ADDR_W'(MASK_ADDR)) reg_rdata = {gie_q, {(PAD_W-1){1'b0}}, mask_q};
    else if (reg_addr == ADDR_W'(PRIO_ADDR)) reg_rdata = {{PAD_W{1'b0}}, prio_q};
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               gie,
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_SRC-1:0] pend,
  output logic               valid,
  output logic [ID_W-1:0]    id
);
  assign pend = req & mask & {NUM_SRC{gie}};
  assign {valid, id} = pick(pend, code);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  REQ_ADDR  = 8'hFA,
  parameter logic [7:0]  MASK_ADDR = 8'hFB,
  parameter logic [7:0]  PRIO_ADDR = 8'hF9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic               irq_ack,
  output logic               irq_valid,
  output logic [ID_W-1:0]    irq_id
);
  // Named internal events, observed by the bound checker.
  logic [NUM_SRC-1:0] edge_evt;
  logic [NUM_SRC-1:0] req_q, mask_q, prio_q, pend;
  logic               gie_q, ack_fire, req_wr;

  assign ack_fire = irq_ack & irq_valid;

  irqc_edge #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src(src_i), .rise(edge_evt)
  );

  irqc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REQ_ADDR(REQ_ADDR), .MASK_ADDR(MASK_ADDR), .PRIO_ADDR(PRIO_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .edge_evt(edge_evt), .ack_fire(ack_fire), .ack_id(irq_id),
    .ie_set(ie_set_i), .ie_clr(ie_clr_i),
    .req_wr(req_wr), .req_q(req_q), .mask_q(mask_q), .gie_q(gie_q), .prio_q(prio_q)
  );

  irqc_arbiter u_arb (
    .req(req_q), .mask(mask_q), .gie(gie_q), .code(prio_q[CODE_W-1:0]),
    .pend(pend), .valid(irq_valid), .id(irq_id)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] edge_evt,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               gie_q,
  input logic               ack_fire,
  input logic               req_wr,
  input logic               irq_valid,
  input logic [ID_W-1:0]    irq_id,
  input logic [7:0]         reg_addr,
  input logic [7:0]         reg_rdata
);
  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((req_q & $past(edge_evt)) == $past(edge_evt))); // R2

  AST_VALID_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie_q); // R3

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_id < ID_W'(NUM_SRC) && req_q[irq_id] && mask_q[irq_id])); // R4

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !gie_q); // R6

  AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !req_wr && !edge_evt[irq_id]) |=> !req_q[$past(irq_id)]); // R6

  AST_REQ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'hFA) |-> (reg_rdata[7:6] == 2'b00)); // R8
endmodule

bind prio_irq_ctrl irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .req_q(req_q), .mask_q(mask_q),
  .gie_q(gie_q), .ack_fire(ack_fire), .req_wr(req_wr), .irq_valid(irq_valid),
  .irq_id(irq_id), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_i = '0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ie_set_i = 1'b0, ie_clr_i = 1'b0, irq_ack = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_id;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(tag, int'(reg_rdata), int'(exp));
    reg_addr = 8'h00;
  endtask

  task automatic pulse_src(input logic [5:0] s);
    src_i = s; @(negedge clk); src_i = '0; @(negedge clk);
  endtask

  // Rank model: group position times two plus odd-index offset; lowest wins.
  function automatic int rank(input int s, input int code);
    int g, pos;
    g = s / 2;
    case (code)
      1: pos = (g == 0) ? 0 : (g == 1) ? 2 : 1;
      2: pos = (g == 0) ? 1 : (g == 1) ? 0 : 2;
      3: pos = (g == 0) ? 2 : (g == 1) ? 0 : 1;
      4: pos = (g == 0) ? 1 : (g == 1) ? 2 : 0;
      5: pos = (g == 0) ? 2 : (g == 1) ? 1 : 0;
      default: pos = g;
    endcase
    return pos * 2 + (s % 2);
  endfunction

  function automatic int winner(input logic [5:0] p, input int code);
    int best = -1;
    for (int s = 0; s < 6; s++)
      if (p[s] && (best < 0 || rank(s, code) < rank(best, code))) best = s;
    return best;
  endfunction

  task automatic t_reset;
    rd_chk("R1 req", 8'hFA, 8'h00);
    rd_chk("R1 mask", 8'hFB, 8'h00);
    rd_chk("R1 prio", 8'hF9, 8'h00);
    chk("R1 valid", int'(irq_valid), 0);
  endtask

  task automatic t_edge_poll;
    pulse_src(6'b001000);
    rd_chk("R2 single edge", 8'hFA, 8'h08);
    chk("R3 no valid with gie off", int'(irq_valid), 0);
    pulse_src(6'b110001);
    rd_chk("R2 multi edge", 8'hFA, 8'h39);
    wr(8'hFA, 8'h00);
    src_i = 6'b000010; @(negedge clk);
    rd_chk("R2 level sets once", 8'hFA, 8'h02);
    wr(8'hFA, 8'h00);
    @(negedge clk); @(negedge clk);
    rd_chk("R2 held level no reset", 8'hFA, 8'h00);
    src_i = '0; @(negedge clk);
  endtask

  task automatic t_mask_gie_ack;
    wr(8'hFA, 8'h08);
    wr(8'hFB, 8'h08);
    chk("R3 masked-in but gie off", int'(irq_valid), 0);
    wr(8'hFB, 8'h84);
    chk("R4 masked-out source", int'(irq_valid), 0);
    wr(8'hFB, 8'h88);
    chk("R4 valid", int'(irq_valid), 1);
    chk("R4 id", int'(irq_id), 3);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd_chk("R6 ack clears req", 8'hFA, 8'h00);
    rd_chk("R6 ack clears gie", 8'hFB, 8'h08);
    chk("R6 valid low after ack", int'(irq_valid), 0);
    wr(8'hFA, 8'h01);
    wr(8'hFB, 8'h01);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd_chk("R6 ack ignored w/o valid", 8'hFA, 8'h01);
    wr(8'hFB, 8'h81);
    irq_ack = 1'b1; ie_set_i = 1'b1; @(negedge clk);
    irq_ack = 1'b0; ie_set_i = 1'b0;
    rd_chk("R7 ack beats enable", 8'hFB, 8'h01);
  endtask

  task automatic t_priority;
    logic [5:0] pats [6] = '{6'h3F, 6'h2A, 6'h15, 6'h30, 6'h0C, 6'h21};
    wr(8'hFB, 8'hBF);
    for (int c = 0; c < 8; c++) begin
      wr(8'hF9, 8'(c));
      foreach (pats[k]) begin
        wr(8'hFA, {2'b00, pats[k]});
        chk($sformatf("R5 code %0d pat %0h", c, pats[k]), int'(irq_id), winner(pats[k], c));
        chk("R4 valid any pending", int'(irq_valid), 1);
      end
    end
  endtask

  task automatic t_strobes;
    wr(8'hFB, 8'h3F);
    ie_set_i = 1'b1; ie_clr_i = 1'b1; @(negedge clk);
    ie_set_i = 1'b0; ie_clr_i = 1'b0;
    rd_chk("R7 clear beats set", 8'hFB, 8'h3F);
    ie_set_i = 1'b1; wr(8'hFB, 8'h3F); ie_set_i = 1'b0;
    rd_chk("R7 set beats write", 8'hFB, 8'hBF);
    ie_clr_i = 1'b1; wr(8'hFB, 8'hBF); ie_clr_i = 1'b0;
    rd_chk("R7 clear beats write", 8'hFB, 8'h3F);
    ie_set_i = 1'b1; @(negedge clk); ie_set_i = 1'b0;
    rd_chk("R7 set alone", 8'hFB, 8'hBF);
    ie_clr_i = 1'b1; @(negedge clk); ie_clr_i = 1'b0;
    rd_chk("R7 clear alone", 8'hFB, 8'h3F);
  endtask

  task automatic t_fields;
    wr(8'hFA, 8'hFF);
    rd_chk("R8 req high bits", 8'hFA, 8'h3F);
    wr(8'hFB, 8'hFF);
    rd_chk("R8 mask bit6", 8'hFB, 8'hBF);
    wr(8'hF9, 8'hFF);
    rd_chk("R8 prio high bits", 8'hF9, 8'h3F);
    wr(8'h10, 8'h00);
    wr(8'hFC, 8'h00);
    rd_chk("R10 req untouched", 8'hFA, 8'h3F);
    rd_chk("R10 mask untouched", 8'hFB, 8'hBF);
    rd_chk("R10 prio untouched", 8'hF9, 8'h3F);
    rd_chk("R10 unmapped read", 8'h10, 8'h00);
  endtask

  task automatic t_collide;
    wr(8'hF9, 8'h00);
    wr(8'hFA, 8'h04);
    wr(8'hFB, 8'h84);
    chk("R9 setup id", int'(irq_id), 2);
    irq_ack = 1'b1; src_i = 6'b000100; @(negedge clk);
    irq_ack = 1'b0; src_i = '0;
    rd_chk("R9 edge survives ack", 8'hFA, 8'h04);
    rd_chk("R9 ack still drops gie", 8'hFB, 8'h04);
    src_i = 6'b000010; wr(8'hFA, 8'h00); src_i = '0;
    rd_chk("R9 edge survives write-0", 8'hFA, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_edge_poll;
    t_mask_gie_ack;
    t_priority;
    t_strobes;
    t_fields;
    t_collide;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule